// File: doc/BRIEF.md
# CEC Bit Transmitter with Edge Trim

This block puts single bits onto an open-drain Consumer Electronics Control line. Each bit has a low phase, in which the block pulls the line down. A released phase follows, in which the line floats high. A bit is either a start bit or a data bit carrying 0 or 1. A 3-bit rise-trim code moves the end of the low phase. A 2-bit fall-trim code shortens the whole bit period, and it shortens a data bit by more than a start bit. All timing is counted in ticks of a 1 µs enable input. The trim codes are captured when a request is accepted, so changing them while a bit is on the line does not affect that bit.

The block can also pull the line low for a fixed 3.6 ms when a receiver reports a bit outside its window. This error pulse either starts at once or waits for the next rising edge seen on the line. A sticky flag records every level change on the sampled line until it is cleared. The state machine has five states: IDLE, BIT_LOW, BIT_HIGH, ERR_WAIT and ERR_LOW. The transitions are:

- IDLE goes to BIT_LOW when a bit is accepted.
- IDLE goes to ERR_LOW or ERR_WAIT when an error request is taken.
- BIT_LOW goes to BIT_HIGH when the low length expires.
- BIT_HIGH goes to IDLE, with a done pulse, when the period expires.
- ERR_WAIT goes to ERR_LOW on a rising line edge.
- ERR_LOW goes to IDLE after 3600 ticks.

Top module: `cec_bit_tx`

## Requirements
- R1: After reset, tx_drive, busy, done and edge_seen are all 0.
- R2: A start bit holds tx_drive high for 3700 ticks plus a rise-trim offset. The offsets are: code 3'b000 gives 0, 3'b001 gives -30, 3'b010 gives -60, 3'b011 gives -90, 3'b100 gives -120, 3'b101 gives -150, 3'b110 gives -180 and 3'b111 gives +30.
- R3: A data bit holds tx_drive high for 1500 ticks when req_bit=0 and for 600 ticks when req_bit=1. The same rise-trim offsets as in R2 apply.
- R4: A start bit's period ends 4500 ticks after acceptance, shortened by 0, 40, 100 or 160 ticks for fall codes 2'b00, 2'b01, 2'b10 and 2'b11. At the end of the period, done is high for exactly one cycle.
- R5: A data bit's period is 2400 ticks, shortened by 0, 190, 250 or 310 ticks for fall codes 2'b00, 2'b01, 2'b10 and 2'b11.
- R6: Timers advance only in cycles where tick_us is 1. Holding tick_us low lengthens the current phase by that many cycles.
- R7: A request is accepted only while busy is 0. Requests made while busy are ignored. Trim codes are captured at acceptance, and later changes to them do not affect the current bit.
- R8: With err_en=1 and err_wait=0, an err_req taken in IDLE holds tx_drive high for 3600 ticks, starting at once.
- R9: With err_wait=1, the error pulse starts only after a rising edge of line_in. Until then, tx_drive stays 0 and busy stays 1.
- R10: An error request has priority over a bit request in the same cycle. That bit request is dropped. With err_en=0, err_req is ignored.
- R11: edge_seen is set by any change of line_in and cleared by edge_clr while the line is stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | 1 µs timing enable |
| req_valid | input | 1 | Bit request |
| req_start | input | 1 | 1 = start bit, 0 = data bit |
| req_bit | input | 1 | Data bit value |
| rise_trim | input | 3 | Rise-edge trim code |
| fall_trim | input | 2 | Fall-edge trim code |
| err_en | input | 1 | Error pulse enable |
| err_wait | input | 1 | 1 = wait for line rising edge before the error pulse |
| err_req | input | 1 | Error pulse request |
| line_in | input | 1 | Sampled line level |
| edge_clr | input | 1 | Clears edge_seen |
| tx_drive | output | 1 | 1 = pull the line low |
| busy | output | 1 | Bit or error pulse in progress |
| done | output | 1 | One-cycle pulse at the end of a bit period |
| edge_seen | output | 1 | Sticky line-edge flag |

## Verification
The bench builds the block with its default parameters, which are the nominal microsecond values. It asserts tick_us in almost every cycle, so one tick equals one clock. Every rise code and every fall code can therefore be measured in exact clock counts within a few thousand cycles per bit, and so can the full 3.6 ms error pulse. A deliberate tick stall shows that the count is gated by tick_us rather than by the clock.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BIT_LOW,
        ST_BIT_HIGH,
        ST_ERR_WAIT,
        ST_ERR_LOW
    } tx_state_e;
endpackage

// File: rtl/cec_trim_calc.sv
module cec_trim_calc #(
    parameter int CNT_W     = 13,
    parameter int START_LOW = 3700,
    parameter int START_PER = 4500,
    parameter int DATA0_LOW = 1500,
    parameter int DATA1_LOW = 600,
    parameter int DATA_PER  = 2400,
    parameter int RISE_STEP = 30,
    parameter int SCUT1 = 40,
    parameter int SCUT2 = 100,
    parameter int SCUT3 = 160,
    parameter int DCUT1 = 190,
    parameter int DCUT2 = 250,
    parameter int DCUT3 = 310
) (
    input  logic             is_start,
    input  logic             bit_val,
    input  logic [2:0]       rise_code,
    input  logic [1:0]       fall_code,
    output logic [CNT_W-1:0] low_len,
    output logic [CNT_W-1:0] per_len
);
    int base_low;
    int base_per;
    int rise_adj;
    int fall_cut;

    always_comb begin
        base_low = is_start ? START_LOW : (bit_val ? DATA1_LOW : DATA0_LOW);
        base_per = is_start ? START_PER : DATA_PER;
        if (rise_code == 3'b111)
            rise_adj = RISE_STEP;
        else
            rise_adj = -(RISE_STEP * int'(rise_code));
        case (fall_code)
            2'd1:    fall_cut = is_start ? SCUT1 : DCUT1;
            2'd2:    fall_cut = is_start ? SCUT2 : DCUT2;
            2'd3:    fall_cut = is_start ? SCUT3 : DCUT3;
            default: fall_cut = 0;
        endcase
        low_len = CNT_W'(base_low + rise_adj);
        per_len = CNT_W'(base_per - fall_cut);
    end
endmodule

// File: rtl/cec_tick_counter.sv
module cec_tick_counter #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cec_line_edge.sv
module cec_line_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic clr,
    output logic rise,
    output logic flag
);
    logic line_prev;

    assign rise = line_in & ~line_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_prev <= 1'b1;
            flag      <= 1'b0;
        end else begin
            line_prev <= line_in;
            if (line_in != line_prev)
                flag <= 1'b1;
            else if (clr)
                flag <= 1'b0;
        end
    end

    assert_edge_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (line_in != line_prev) |=> flag);
    assert_clear_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && line_in == line_prev) |=> !flag);
endmodule

// File: rtl/cec_bit_tx.sv
module cec_bit_tx #(
    parameter int START_LOW = 3700,
    parameter int START_PER = 4500,
    parameter int DATA0_LOW = 1500,
    parameter int DATA1_LOW = 600,
    parameter int DATA_PER  = 2400,
    parameter int RISE_STEP = 30,
    parameter int SCUT1 = 40,
    parameter int SCUT2 = 100,
    parameter int SCUT3 = 160,
    parameter int DCUT1 = 190,
    parameter int DCUT2 = 250,
    parameter int DCUT3 = 310,
    parameter int ERR_LEN = 3600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       req_valid,
    input  logic       req_start,
    input  logic       req_bit,
    input  logic [2:0] rise_trim,
    input  logic [1:0] fall_trim,
    input  logic       err_en,
    input  logic       err_wait,
    input  logic       err_req,
    input  logic       line_in,
    input  logic       edge_clr,
    output logic       tx_drive,
    output logic       busy,
    output logic       done,
    output logic       edge_seen
);
    import cec_tx_pkg::*;

    localparam int MAX_A   = (START_LOW + RISE_STEP > START_PER) ? START_LOW + RISE_STEP : START_PER;
    localparam int MAX_B   = (DATA_PER > ERR_LEN) ? DATA_PER : ERR_LEN;
    localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] low_calc, per_calc;
    logic [CNT_W-1:0] low_q, per_q;
    logic             line_rise;
    logic             err_take, bit_take;
    logic             cnt_clr, cnt_inc;

    cec_trim_calc #(
        .CNT_W(CNT_W), .START_LOW(START_LOW), .START_PER(START_PER),
        .DATA0_LOW(DATA0_LOW), .DATA1_LOW(DATA1_LOW), .DATA_PER(DATA_PER),
        .RISE_STEP(RISE_STEP), .SCUT1(SCUT1), .SCUT2(SCUT2), .SCUT3(SCUT3),
        .DCUT1(DCUT1), .DCUT2(DCUT2), .DCUT3(DCUT3)
    ) u_trim (
        .is_start (req_start),
        .bit_val  (req_bit),
        .rise_code(rise_trim),
        .fall_code(fall_trim),
        .low_len  (low_calc),
        .per_len  (per_calc)
    );

    cec_tick_counter #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .cnt  (cnt)
    );

    cec_line_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(line_in),
        .clr    (edge_clr),
        .rise   (line_rise),
        .flag   (edge_seen)
    );

    assign err_take = (state_q == ST_IDLE) && err_req && err_en;
    assign bit_take = (state_q == ST_IDLE) && req_valid && !err_take;
    assign cnt_clr  = (state_q == ST_IDLE) || (state_q == ST_ERR_WAIT);
    assign cnt_inc  = tick_us && (state_q == ST_BIT_LOW || state_q == ST_BIT_HIGH
                                  || state_q == ST_ERR_LOW);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (err_take)
                    state_d = err_wait ? ST_ERR_WAIT : ST_ERR_LOW;
                else if (bit_take)
                    state_d = ST_BIT_LOW;
            end
            ST_BIT_LOW:
                if (tick_us && cnt == low_q - 1'b1) state_d = ST_BIT_HIGH;
            ST_BIT_HIGH:
                if (tick_us && cnt == per_q - 1'b1) state_d = ST_IDLE;
            ST_ERR_WAIT:
                if (line_rise) state_d = ST_ERR_LOW;
            ST_ERR_LOW:
                if (tick_us && cnt == CNT_W'(ERR_LEN - 1)) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and captured bit lengths
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            low_q   <= '0;
            per_q   <= '0;
        end else begin
            state_q <= state_d;
            if (bit_take) begin
                low_q <= low_calc;
                per_q <= per_calc;
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= (state_q == ST_BIT_HIGH) && (state_d == ST_IDLE);
    end

    always_comb begin
        tx_drive = (state_q == ST_BIT_LOW) || (state_q == ST_ERR_LOW);
        busy     = (state_q != ST_IDLE);
    end

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    assert_cnt_in_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BIT_LOW || state_q == ST_BIT_HIGH) |-> cnt < per_q);
    assert_tick_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_us && (state_q == ST_BIT_LOW || state_q == ST_BIT_HIGH)) |=> $stable(cnt));
    assert_len_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(low_q) && $stable(per_q)));
    assert_wait_for_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERR_WAIT && !line_rise) |=> state_q != ST_ERR_LOW);
endmodule

// File: tb/test_cec_bit_tx.sv
module test_cec_bit_tx;
    typedef struct {
        int low;
        int per;
        string tag;
    } exp_t;

    logic clk = 0;
    logic rst_n = 0;
    logic tick_us = 1;
    logic req_valid = 0, req_start = 0, req_bit = 0;
    logic [2:0] rise_trim = 0;
    logic [1:0] fall_trim = 0;
    logic err_en = 0, err_wait = 0, err_req = 0;
    logic edge_clr = 0;
    logic ext_pull = 0;
    logic line_in;
    logic tx_drive, busy, done, edge_seen;

    int checks = 0;
    int fails = 0;
    int done_total = 0;
    int cyc = 0;
    int n0 = 0;
    int lowcnt = 0;
    logic drv_prev = 0;
    logic mon_skip = 1;
    exp_t sb[$];

    always #4 clk = ~clk;

    assign line_in = !(tx_drive | ext_pull);

    cec_bit_tx i_cec_bit_tx (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
        .req_valid(req_valid), .req_start(req_start), .req_bit(req_bit),
        .rise_trim(rise_trim), .fall_trim(fall_trim),
        .err_en(err_en), .err_wait(err_wait), .err_req(err_req),
        .line_in(line_in), .edge_clr(edge_clr),
        .tx_drive(tx_drive), .busy(busy), .done(done), .edge_seen(edge_seen)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int rise_off(input int code);
        return (code == 7) ? 30 : -30 * code;
    endfunction

    function automatic int fall_cut(input bit st, input int code);
        int s[4] = '{0, 40, 100, 160};
        int d[4] = '{0, 190, 250, 310};
        return st ? s[code] : d[code];
    endfunction

    // monitor: measures each bit and compares against the scoreboard
    always @(negedge clk) begin
        cyc++;
        if (done) done_total++;
        if (!mon_skip) begin
            if (tx_drive && !drv_prev) begin
                n0 = cyc;
                lowcnt = 0;
            end
            if (tx_drive) lowcnt++;
            if (done) begin
                if (sb.size() == 0) begin
                    check(0, "R4 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(lowcnt == e.low, {e.tag, " low"}, lowcnt, e.low);
                    check(cyc - n0 == e.per, {e.tag, " period"}, cyc - n0, e.per);
                end
            end
        end
        drv_prev = tx_drive;
    end

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic send_bit(input bit st, input bit val, input int rc, input int fc,
                            input int stall, input string tag);
        exp_t e;
        int base_low;
        base_low = st ? 3700 : (val ? 600 : 1500);
        e.low = base_low + rise_off(rc) + stall;
        e.per = (st ? 4500 : 2400) - fall_cut(st, fc) + stall;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        req_start = st;
        req_bit = val;
        rise_trim = 3'(rc);
        fall_trim = 2'(fc);
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        rise_trim = 3'(7 - rc);            // R7: later trim changes must not matter
        fall_trim = 2'(3 - fc);
        if (stall > 0) begin
            repeat (10) @(negedge clk);
            tick_us = 0;
            repeat (stall) @(negedge clk);
            tick_us = 1;
        end
        wait_idle();
    endtask

    task automatic measure_err(input string tag);
        int n = 0;
        while (busy) begin
            if (tx_drive) n++;
            @(negedge clk);
        end
        check(n == 3600, tag, n, 3600);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int dn;
        repeat (5) @(negedge clk);
        check(tx_drive == 0, "R1 tx_drive", tx_drive, 0);
        check(busy == 0, "R1 busy", busy, 0);
        check(done == 0, "R1 done", done, 0);
        check(edge_seen == 0, "R1 edge_seen", edge_seen, 0);
        rst_n = 1;
        @(negedge clk);
        check(edge_seen == 0, "R1 edge_seen after release", edge_seen, 0);
        mon_skip = 0;

        // R2 / R4: every rise code and every fall code on start bits
        for (int rc = 0; rc < 8; rc++)
            send_bit(1, 0, rc, rc % 4, 0, "R2 R4 start bit");

        // R3 / R5: data bits
        send_bit(0, 0, 0, 0, 0, "R3 R5 data0 nominal");
        send_bit(0, 0, 3, 1, 0, "R3 R5 data0 trims");
        send_bit(0, 1, 0, 2, 0, "R3 R5 data1");
        send_bit(0, 1, 6, 3, 0, "R3 R5 data1 min low");
        send_bit(0, 1, 7, 0, 0, "R3 R5 data1 late rise");
        send_bit(0, 0, 7, 3, 0, "R3 R5 data0 late rise short");

        // R6: tick stall lengthens the phase
        send_bit(0, 0, 2, 1, 50, "R6 tick stall");

        // R7: requests while busy are ignored
        begin
            exp_t e;
            e.low = 3700; e.per = 4500; e.tag = "R7 busy bit";
            sb.push_back(e);
            @(negedge clk);
            req_start = 1; req_bit = 0; rise_trim = 0; fall_trim = 0; req_valid = 1;
            @(negedge clk);
            req_valid = 0;
            repeat (100) @(negedge clk);
            req_start = 0; req_bit = 1; rise_trim = 3'd6; fall_trim = 2'd3; req_valid = 1;
            repeat (20) @(negedge clk);
            req_valid = 0;
            dn = done_total;
            wait_idle();
            repeat (5) @(negedge clk);
            check(busy == 0, "R7 no second bit busy", busy, 0);
            check(done_total == dn + 1, "R7 one done", done_total - dn, 1);
            check(sb.size() == 0, "R7 scoreboard empty", sb.size(), 0);
        end

        mon_skip = 1;

        // R11: clear and re-set the edge flag
        @(negedge clk) edge_clr = 1;
        @(negedge clk) edge_clr = 0;
        check(edge_seen == 0, "R11 cleared", edge_seen, 0);
        ext_pull = 1;
        @(negedge clk);
        check(edge_seen == 1, "R11 set on fall", edge_seen, 1);
        ext_pull = 0;
        @(negedge clk);
        @(negedge clk) edge_clr = 1;
        @(negedge clk) edge_clr = 0;
        check(edge_seen == 0, "R11 cleared again", edge_seen, 0);

        // R8 + R10: immediate error pulse with a competing bit request
        err_en = 1; err_wait = 0;
        dn = done_total;
        @(negedge clk);
        err_req = 1; req_valid = 1; req_start = 0; req_bit = 1;
        @(negedge clk);
        err_req = 0; req_valid = 0;
        check(tx_drive == 1, "R8 pulse starts at once", tx_drive, 1);
        measure_err("R8 error pulse length");
        repeat (5) @(negedge clk);
        check(busy == 0, "R10 bit request dropped", busy, 0);
        check(done_total == dn, "R10 no done", done_total - dn, 0);

        // R9: wait for rising edge
        err_wait = 1;
        @(negedge clk) err_req = 1;
        @(negedge clk) err_req = 0;
        repeat (100) @(negedge clk);
        check(busy == 1, "R9 busy while waiting", busy, 1);
        check(tx_drive == 0, "R9 no drive before rise", tx_drive, 0);
        ext_pull = 1;
        repeat (20) @(negedge clk);
        check(tx_drive == 0, "R9 no drive on fall", tx_drive, 0);
        ext_pull = 0;
        @(negedge clk);
        check(tx_drive == 1, "R9 starts after rise", tx_drive, 1);
        measure_err("R9 error pulse length");

        // R10: disabled error request is ignored
        err_en = 0; err_wait = 0;
        @(negedge clk) err_req = 1;
        @(negedge clk) err_req = 0;
        repeat (5) @(negedge clk);
        check(busy == 0, "R10 disabled busy", busy, 0);
        check(tx_drive == 0, "R10 disabled drive", tx_drive, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule